// File: doc/BRIEF.md
# Fault and Enable Supervisor

This block decides, clock by clock, whether the switching controller may drive its power switch. It takes flags that other logic has already synchronized and compared against thresholds: supply good, supply over-voltage, enable pin, die over-temperature, open feedback loop, open current-sense pin and shorted output rectifier. It also takes a per-cycle strobe that reports whether the PWM generator hit its current limit during the cycle that just ended. From these it runs start-up, shutdown, pause and automatic-restart behaviour. Each fault class has its own reaction and its own timing.

The supervisor has four states: stopped, running, held off by over-voltage, and hiccup. Some faults need a deglitch window before they act: the disable command, over-voltage and open feedback. Overload is timed against a long window. Current-sense and rectifier faults act after a few consecutive bad cycles. Over-temperature only masks the permission and does not change state. Overload, open feedback and the fast faults enter a hiccup off period, which is a whole multiple of the overload window, before a restart is tried. A status word reports live conditions and the cause that is holding the controller off.

Top module: `fault_supervisor`

## Requirements
- R1: During and after reset the state is stopped, `switchEn` is 0 and the cause bits `faultStatus[5:2]` are 0. The live bits still follow their inputs.
- R2: From the stopped state, `switchEn` rises one clock after an edge at which `supplyOk` and `enableIn` are both 1.
- R3: While running, an edge with `supplyOk` at 0 stops the controller at that edge. `faultStatus[0]` equals the inverse of `supplyOk` at all times.
- R4: `enableIn` must be low for DEG_TICKS consecutive clocks before the controller stops, one clock later. Shorter low pulses have no effect. `faultStatus[1]` is 1 while stopped with `enableIn` low.
- R5: `overVolt` held for DEG_TICKS clocks moves the controller, one clock later, into an over-voltage hold with `faultStatus[2]` set. The hold ends at the first edge where `overVolt` is 0 and goes to stopped. A restart follows one clock after that. Shorter pulses are ignored.
- R6: A cycle-end strobe with `limHit` starts the overload timer. The timer then advances every clock, and a cycle-end strobe without `limHit` clears it. When the timer reaches OLP_TICKS, the next edge enters hiccup with `faultStatus[3]` set.
- R7: `fbOpen` held for OLP_TICKS clocks enters hiccup one clock later with `faultStatus[4]` set. Shorter episodes are ignored.
- R8: FAST_CYCLES consecutive cycle-end strobes with `csOpen` or `rectShort` enter hiccup one clock later with `faultStatus[5]` set. A cycle-end strobe with neither flag resets the count.
- R9: Hiccup lasts OLP_TICKS×HICCUP_MULT clocks and then goes to stopped, clearing the cause bit. The restart rule of R2 then applies.
- R10: `overTemp` forces `switchEn` to 0 in the same cycle without changing state. `faultStatus[6]` mirrors it.
- R11: When over-voltage and another hiccup fault trip on the same edge, the over-voltage hold wins.
- R12: At most one of the cause bits `faultStatus[5:2]` is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyOk | input | 1 | Supply above lockout (hysteresis applied upstream) |
| enableIn | input | 1 | Enable pin high or floating |
| overVolt | input | 1 | Supply above over-voltage level |
| overTemp | input | 1 | Die over-temperature (hysteretic) |
| fbOpen | input | 1 | Feedback node above open-loop level |
| csOpen | input | 1 | Current-sense pin seen open this cycle |
| rectShort | input | 1 | Rectifier short seen this cycle |
| cycleEnd | input | 1 | One-clock strobe at the end of a switching cycle |
| limHit | input | 1 | Current limit was hit in the ending cycle (valid with cycleEnd) |
| switchEn | output | 1 | Permission to switch |
| faultStatus | output | 7 | [0] lockout, [1] disabled, [2] over-voltage, [3] overload, [4] open feedback, [5] fast fault, [6] over-temperature |

## Verification
The assertions check properties that hold on every cycle. Over-temperature and the over-voltage hold must mask permission, a lockout edge must remove it, at most one cause bit may be set, and leaving hiccup must never grant permission in the same cycle. Only the bench's scenarios can show the exact timing. That covers the exact trip cycle of each deglitch window, the overload timer being cleared by a clean cycle, the consecutive-cycle count of fast faults, the hiccup length, and which cause wins when two faults trip on the same edge.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_OVP, ST_HIC} fsupState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrDetect;
    logic clrHiccup;
  } fsupCtl_t;

  // datapath -> control events
  typedef struct packed {
    logic disTrip;
    logic ovpTrip;
    logic fbTrip;
    logic olpTrip;
    logic fastTrip;
    logic hicDone;
  } fsupEvt_t;

  localparam int STATUS_W = 7;
  localparam int BIT_UVLO = 0;
  localparam int BIT_DIS  = 1;
  localparam int BIT_OVP  = 2;
  localparam int BIT_OLP  = 3;
  localparam int BIT_FB   = 4;
  localparam int BIT_FAST = 5;
  localparam int BIT_OTP  = 6;
endpackage

// File: rtl/fsup_deglitch.sv
module fsup_deglitch #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic raw,
  output logic trip
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              runLen <= '0;
    else if (clr || !raw)   runLen <= '0;
    else if (runLen != LIM) runLen <= runLen + 1'b1;
  end

  assign trip = (runLen == LIM);
endmodule

// File: rtl/fsup_datapath.sv
module fsup_datapath
  import fsup_pkg::*;
#(
  parameter int DEG_TICKS   = 2000,
  parameter int OLP_TICKS   = 5600000,
  parameter int HICCUP_MULT = 4,
  parameter int FAST_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  fsupCtl_t ctl,
  input  logic     enableIn,
  input  logic     overVolt,
  input  logic     fbOpen,
  input  logic     csOpen,
  input  logic     rectShort,
  input  logic     cycleEnd,
  input  logic     limHit,
  output fsupEvt_t evt
);
  localparam int NUM_DG = 3;
  localparam int HIC_TICKS = OLP_TICKS * HICCUP_MULT;
  localparam int OW = $clog2(OLP_TICKS + 1);
  localparam int FW = $clog2(FAST_CYCLES + 1);
  localparam int HW = $clog2(HIC_TICKS + 1);
  localparam logic [OW-1:0] OLP_LIM  = OW'(OLP_TICKS);
  localparam logic [FW-1:0] FAST_LIM = FW'(FAST_CYCLES);
  localparam logic [HW-1:0] HIC_LAST = HW'(HIC_TICKS - 1);

  // deglitched detectors: 0 disable, 1 over-voltage, 2 open feedback
  logic [NUM_DG-1:0] dgRaw;
  logic [NUM_DG-1:0] dgTrip;
  assign dgRaw = {fbOpen, overVolt, !enableIn};

  for (genvar gi = 0; gi < NUM_DG; gi++) begin : g_dg
    fsup_deglitch #(
      .LIMIT((gi == 2) ? OLP_TICKS : DEG_TICKS)
    ) u_dg (
      .clk (clk),
      .rstN(rstN),
      .clr (ctl.clrDetect),
      .raw (dgRaw[gi]),
      .trip(dgTrip[gi])
    );
  end

  // overload timer
  logic [OW-1:0] olpCnt;
  logic [OW-1:0] olpInc;
  assign olpInc = (olpCnt == OLP_LIM) ? olpCnt : olpCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              olpCnt <= '0;
    else if (ctl.clrDetect) olpCnt <= '0;
    else if (cycleEnd)      olpCnt <= limHit ? olpInc : '0;
    else if (olpCnt != '0)  olpCnt <= olpInc;
  end

  // consecutive bad-cycle counter
  logic [FW-1:0] fastCnt;
  logic          badCycle;
  assign badCycle = csOpen || rectShort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              fastCnt <= '0;
    else if (ctl.clrDetect) fastCnt <= '0;
    else if (cycleEnd) begin
      if (!badCycle)                fastCnt <= '0;
      else if (fastCnt != FAST_LIM) fastCnt <= fastCnt + 1'b1;
    end
  end

  // hiccup off-period timer
  logic [HW-1:0] hicCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  hicCnt <= '0;
    else if (ctl.clrHiccup)     hicCnt <= '0;
    else if (hicCnt != HIC_LAST) hicCnt <= hicCnt + 1'b1;
  end

  always_comb begin
    evt.disTrip  = dgTrip[0];
    evt.ovpTrip  = dgTrip[1];
    evt.fbTrip   = dgTrip[2];
    evt.olpTrip  = (olpCnt == OLP_LIM);
    evt.fastTrip = (fastCnt == FAST_LIM);
    evt.hicDone  = (hicCnt == HIC_LAST);
  end
endmodule

// File: rtl/fsup_control.sv
module fsup_control
  import fsup_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                supplyOk,
  input  logic                enableIn,
  input  logic                overVolt,
  input  logic                overTemp,
  input  fsupEvt_t            evt,
  output fsupCtl_t            ctl,
  output logic                switchEn,
  output logic [STATUS_W-1:0] faultStatus
);
  fsupState_e state, stateNxt;
  logic [3:0] cause, causeNxt; // one-hot: ovp, olp, fb, fast

  always_comb begin
    stateNxt = state;
    causeNxt = cause;
    unique case (state)
      ST_OFF: if (supplyOk && enableIn) stateNxt = ST_RUN;
      ST_RUN: begin
        if (!supplyOk || evt.disTrip) stateNxt = ST_OFF;
        else if (evt.ovpTrip) begin
          stateNxt = ST_OVP; causeNxt = 4'b0001;
        end else if (evt.olpTrip) begin
          stateNxt = ST_HIC; causeNxt = 4'b0010;
        end else if (evt.fbTrip) begin
          stateNxt = ST_HIC; causeNxt = 4'b0100;
        end else if (evt.fastTrip) begin
          stateNxt = ST_HIC; causeNxt = 4'b1000;
        end
      end
      ST_OVP: if (!supplyOk || !overVolt) stateNxt = ST_OFF;
      ST_HIC: if (evt.hicDone) stateNxt = ST_OFF;
      default: stateNxt = ST_OFF;
    endcase
    if (stateNxt == ST_OFF) causeNxt = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OFF;
      cause <= '0;
    end else begin
      state <= stateNxt;
      cause <= causeNxt;
    end
  end

  always_comb begin
    ctl.clrDetect = (state != ST_RUN);
    ctl.clrHiccup = (state != ST_HIC);
  end

  assign switchEn = (state == ST_RUN) && !overTemp;

  always_comb begin
    faultStatus = '0;
    faultStatus[BIT_UVLO] = !supplyOk;
    faultStatus[BIT_DIS]  = (state == ST_OFF) && !enableIn;
    faultStatus[BIT_OVP]  = cause[0];
    faultStatus[BIT_OLP]  = cause[1];
    faultStatus[BIT_FB]   = cause[2];
    faultStatus[BIT_FAST] = cause[3];
    faultStatus[BIT_OTP]  = overTemp;
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int DEG_TICKS   = 2000,
  parameter int OLP_TICKS   = 5600000,
  parameter int HICCUP_MULT = 4,
  parameter int FAST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       enableIn,
  input  logic       overVolt,
  input  logic       overTemp,
  input  logic       fbOpen,
  input  logic       csOpen,
  input  logic       rectShort,
  input  logic       cycleEnd,
  input  logic       limHit,
  output logic       switchEn,
  output logic [6:0] faultStatus
);
  fsupCtl_t ctl;
  fsupEvt_t evt;

  fsup_datapath #(
    .DEG_TICKS  (DEG_TICKS),
    .OLP_TICKS  (OLP_TICKS),
    .HICCUP_MULT(HICCUP_MULT),
    .FAST_CYCLES(FAST_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .enableIn (enableIn),
    .overVolt (overVolt),
    .fbOpen   (fbOpen),
    .csOpen   (csOpen),
    .rectShort(rectShort),
    .cycleEnd (cycleEnd),
    .limHit   (limHit),
    .evt      (evt)
  );

  fsup_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .enableIn   (enableIn),
    .overVolt   (overVolt),
    .overTemp   (overTemp),
    .evt        (evt),
    .ctl        (ctl),
    .switchEn   (switchEn),
    .faultStatus(faultStatus)
  );
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       supplyOk,
  input logic       overTemp,
  input logic       switchEn,
  input logic [6:0] faultStatus
);
  p_otp_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |-> !switchEn);

  p_uvlo_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !switchEn);

  p_start_needs_supply_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchEn) |-> $past(supplyOk));

  p_ovp_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultStatus[2] |-> !switchEn);

  p_cause_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(faultStatus[5:2]));

  p_hiccup_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultStatus[3]) |-> !switchEn);
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .supplyOk   (supplyOk),
  .overTemp   (overTemp),
  .switchEn   (switchEn),
  .faultStatus(faultStatus)
);

// File: tb/fault_supervisor_test.sv
module fault_supervisor_test;
  localparam int DEG  = 5;
  localparam int OLP  = 12;
  localparam int MULT = 3;
  localparam int FAST = 4;
  localparam int HIC  = OLP * MULT;

  logic clk = 1'b0;
  logic rstN, supplyOk, enableIn, overVolt, overTemp, fbOpen;
  logic csOpen, rectShort, cycleEnd, limHit;
  logic switchEn;
  logic [6:0] faultStatus;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fault_supervisor #(
    .DEG_TICKS(DEG), .OLP_TICKS(OLP), .HICCUP_MULT(MULT), .FAST_CYCLES(FAST)
  ) uut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enableIn(enableIn),
    .overVolt(overVolt), .overTemp(overTemp), .fbOpen(fbOpen),
    .csOpen(csOpen), .rectShort(rectShort), .cycleEnd(cycleEnd),
    .limHit(limHit), .switchEn(switchEn), .faultStatus(faultStatus)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called right after the edge that entered hiccup; fault inputs already removed
  task automatic waitHiccup(string req);
    repeat (HIC) tick();
    chk(req, {31'd0, switchEn}, 0);
    chk(req, {25'd0, faultStatus}, 0);
    tick();
    chk(req, {31'd0, switchEn}, 1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0; supplyOk = 0; enableIn = 1; overVolt = 0; overTemp = 0;
    fbOpen = 0; csOpen = 0; rectShort = 0; cycleEnd = 0; limHit = 0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 switchEn", {31'd0, switchEn}, 0);
    chk("R1 status", {25'd0, faultStatus}, 7'b0000001);
    rstN = 1;
    tick();
    chk("R1 held by lockout", {31'd0, switchEn}, 0);
    // R2 start
    supplyOk = 1;
    tick();
    chk("R2 start", {31'd0, switchEn}, 1);
    chk("R2 status", {25'd0, faultStatus}, 0);

    // R4 disable deglitch sweep
    for (int len = 1; len <= DEG; len++) begin
      enableIn = 0;
      repeat (len) tick();
      enableIn = 1;
      tick();
      chk("R4 disable pulse", {31'd0, switchEn}, (len < DEG) ? 1 : 0);
      tick();
      chk("R4 recover", {31'd0, switchEn}, 1);
    end
    enableIn = 0;
    repeat (DEG + 1) tick();
    chk("R4 stopped", {31'd0, switchEn}, 0);
    chk("R4 status", {25'd0, faultStatus}, 7'b0000010);
    enableIn = 1;
    tick();
    chk("R4 restart", {31'd0, switchEn}, 1);

    // R3 lockout
    supplyOk = 0;
    tick();
    chk("R3 stop", {31'd0, switchEn}, 0);
    chk("R3 status", {25'd0, faultStatus}, 7'b0000001);
    supplyOk = 1;
    tick();
    chk("R3 restart", {31'd0, switchEn}, 1);

    // R10 over-temperature pause
    overTemp = 1;
    #1;
    chk("R10 immediate", {31'd0, switchEn}, 0);
    chk("R10 status", {25'd0, faultStatus}, 7'b1000000);
    repeat (4) tick();
    chk("R10 held", {31'd0, switchEn}, 0);
    overTemp = 0;
    #1;
    chk("R10 resume", {31'd0, switchEn}, 1);

    // R5 over-voltage
    overVolt = 1;
    repeat (DEG - 1) tick();
    overVolt = 0;
    tick();
    chk("R5 short pulse", {31'd0, switchEn}, 1);
    overVolt = 1;
    repeat (DEG) tick();
    chk("R5 before trip", {31'd0, switchEn}, 1);
    tick();
    chk("R5 tripped", {31'd0, switchEn}, 0);
    chk("R5 status", {25'd0, faultStatus}, 7'b0000100);
    repeat (10) tick();
    chk("R5 hold", {31'd0, switchEn}, 0);
    overVolt = 0;
    tick();
    chk("R5 release", {25'd0, faultStatus}, 0);
    chk("R5 release off", {31'd0, switchEn}, 0);
    tick();
    chk("R5 restart", {31'd0, switchEn}, 1);

    // R6 overload: clean cycle clears the timer
    cycleEnd = 1; limHit = 1;
    repeat (OLP - 1) tick();
    limHit = 0; tick();
    limHit = 1;
    repeat (OLP - 1) tick();
    limHit = 0; tick();
    cycleEnd = 0;
    chk("R6 gap clears", {31'd0, switchEn}, 1);
    repeat (OLP + 2) tick();
    chk("R6 no timer after clean", {31'd0, switchEn}, 1);
    cycleEnd = 1; limHit = 1; tick();
    cycleEnd = 0; limHit = 0;
    repeat (OLP - 1) tick();
    chk("R6 before trip", {31'd0, switchEn}, 1);
    tick();
    chk("R6 tripped", {31'd0, switchEn}, 0);
    chk("R6 status", {25'd0, faultStatus}, 7'b0001000);
    waitHiccup("R9 overload hiccup");

    // R7 open feedback
    fbOpen = 1;
    repeat (OLP - 1) tick();
    fbOpen = 0; tick();
    chk("R7 short", {31'd0, switchEn}, 1);
    fbOpen = 1;
    repeat (OLP) tick();
    chk("R7 before trip", {31'd0, switchEn}, 1);
    tick();
    chk("R7 tripped", {31'd0, switchEn}, 0);
    chk("R7 status", {25'd0, faultStatus}, 7'b0010000);
    fbOpen = 0;
    waitHiccup("R9 feedback hiccup");

    // R8 fast faults
    cycleEnd = 1;
    for (int k = 1; k < FAST; k++) begin
      csOpen = 1;
      repeat (k) tick();
      csOpen = 0;
      tick();
      chk("R8 short run", {31'd0, switchEn}, 1);
    end
    rectShort = 1;
    repeat (FAST) tick();
    chk("R8 before trip", {31'd0, switchEn}, 1);
    tick();
    chk("R8 tripped", {31'd0, switchEn}, 0);
    chk("R8 status", {25'd0, faultStatus}, 7'b0100000);
    rectShort = 0; cycleEnd = 0;
    waitHiccup("R9 fast hiccup");

    // R11 same-edge trip: over-voltage wins
    fbOpen = 1;
    repeat (OLP - DEG) tick();
    overVolt = 1;
    repeat (DEG) tick();
    chk("R11 before", {31'd0, switchEn}, 1);
    tick();
    chk("R11 cause", {25'd0, faultStatus}, 7'b0000100);
    fbOpen = 0; overVolt = 0;
    tick();
    tick();
    chk("R11 restart", {31'd0, switchEn}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule